// File: doc/BRIEF.md
# Pseudo-Silver-Ratio SAR Sequencer

This block steps a successive-approximation converter through M = 2(N-1) comparisons for an N-bit result. The first step places the reference at mid-scale. Each later weight appears twice in a row, so the weights after the first step form a chain of equal binary pairs that ends in three unit weights. For N = 6 the weight chain is 32, 8, 8, 4, 4, 2, 2, 1, 1, 1. The extra steps let the converter recover from a wrong comparator decision, as long as the input lies within that step's correctable margin. A late step then pulls the reference back to the right code.

Each step waits a settling time before the comparator bit is taken. Only two base lengths are programmed, a short one and a long one, both given as cycle counts. The block assigns one of them to each step by a fixed pattern, and a doubled short period covers the one step that needs it. When the timer for a step runs out, the block raises a one-cycle compare strobe and takes the comparator bit in that cycle. The final code comes from an adder that sums two binary-weighted words built from alternate decisions. The adder's carry-in and the result's LSB come from the last two decisions. The surrounding analog path drives `cmp_bit` from the DAC code that `dac_code` presents.

Top module: `psr_sar_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `dac_code`, `cmp_strobe`, `result` and `done` are all zero.
- R2: A `start` seen while no conversion runs begins one, and step 1 presents the code 2^(N-1) on `dac_code`.
- R3: After step k (1-based) with decision d, `dac_code` moves up (d=1) or down (d=0) by the weight of step k+1. Step k takes weight 2^(N-1) for k=1, weight 1 for k >= M-2, and otherwise weight 2^floor((M-1-k)/2). `dac_code` does not change between strobes.
- R4: Step 1 lasts the short count S. Its strobe falls in cycle S, counted from the first cycle after the start edge.
- R5: Steps 2 to M-2 alternate: odd-numbered steps last S cycles and even-numbered steps last the long count L. One step's length is the distance between its strobe and the previous strobe.
- R6: Step M-1 lasts 2*S cycles and step M lasts L cycles.
- R7: `cmp_bit` is taken only in a cycle where `cmp_strobe` is high. Its value in every other cycle has no effect on the reference or on the result.
- R8: With an error-free comparator, every input level 0..2^N-1 converts to its own code. `done` is high for exactly the one cycle after the final strobe, and `result` holds until the next conversion ends.
- R9: A single wrong decision at a step k <= M-2 still gives the ideal code when |Vin - Vref(k)| < q(k). Here q(1) = 2^(N-2), and q(k) equals the weight of step k for 2 <= k <= M-2.
- R10: `result` equals the final reference when the last decision is 1, and that reference minus one when it is 0. It is formed as {X + Y + d(M-1), d(M)}, where X packs d1,d3,...,d(M-3) and Y packs d2,d4,...,d(M-2), each MSB first.
- R11: `start` is ignored while a conversion runs, including the final strobe cycle. A `start` in the `done` cycle launches the next conversion at once.
- R12: A programmed count of zero acts as one cycle, so the doubled period becomes two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion when idle |
| cmp_bit | input | 1 | Comparator decision, 1 when input is at or above the reference |
| short_cyc | input | CW | Short settling period in cycles |
| long_cyc | input | CW | Long settling period in cycles |
| dac_code | output | N | Reference code driving the DAC |
| cmp_strobe | output | 1 | High in the cycle the comparator bit is taken |
| result | output | N | Converted code |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
Two events can fall in the same cycle: the final compare strobe, which finishes the conversion, and a new `start` request. They meet again one cycle later, when the `done` pulse coincides with a fresh `start`. The bench raises `start` in exactly the final strobe cycle and expects it to be dropped. After `done` it watches for a quiet period with no strobe. Then it raises `start` in the `done` cycle itself. There the previous result must still be correct, and the next conversion's first strobe must come after the short count, as if launched from idle.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [1:0] {
    PER_SHORT  = 2'd0,
    PER_LONG   = 2'd1,
    PER_DOUBLE = 2'd2
  } per_kind_e;

  // Settling class of 0-based step s in an m-step conversion.
  function automatic per_kind_e step_kind(input int s, input int m);
    int k;
    k = s + 1;
    if (k == 1)          return PER_SHORT;
    else if (k == m - 1) return PER_DOUBLE;
    else if (k == m)     return PER_LONG;
    else if (k % 2 == 1) return PER_SHORT;
    else                 return PER_LONG;
  endfunction

  // Reference weight of 0-based step s for an n-bit converter.
  function automatic int step_weight(input int s, input int n);
    int m;
    int k;
    m = 2 * (n - 1);
    k = s + 1;
    if (k == 1)     return 1 << (n - 1);
    if (k >= m - 2) return 1;
    return 1 << ((m - 1 - k) / 2);
  endfunction

endpackage

// File: rtl/psr_step_timer.sv
module psr_step_timer
  import psr_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  per_kind_e     kind,
  input  logic [CW-1:0] short_cyc,
  input  logic [CW-1:0] long_cyc,
  output logic          strobe
);

  localparam int TW = CW + 1;

  logic [TW-1:0] cnt;
  logic [TW-1:0] s_len;
  logic [TW-1:0] l_len;
  logic [TW-1:0] per_sel;

  // Zero counts are promoted to one cycle; the doubled period is built from the short one.
  always_comb begin
    s_len = (short_cyc == '0) ? TW'(1) : TW'(short_cyc);
    l_len = (long_cyc  == '0) ? TW'(1) : TW'(long_cyc);
    case (kind)
      PER_SHORT:  per_sel = s_len;
      PER_LONG:   per_sel = l_len;
      PER_DOUBLE: per_sel = s_len << 1;
      default:    per_sel = s_len;
    endcase
  end

  // cnt holds the cycles left in the step including the current one.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      strobe <= 1'b0;
    end else if (load) begin
      cnt    <= per_sel;
      strobe <= (per_sel == TW'(1));
    end else if (cnt != '0) begin
      cnt    <= cnt - TW'(1);
      strobe <= (cnt == TW'(2));
    end else begin
      strobe <= 1'b0;
    end
  end

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt != '0)); // R12

endmodule

// File: rtl/psr_ref_track.sv
module psr_ref_track
  import psr_pkg::*;
#(
  parameter int N  = 8,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          adv,
  input  logic          up,
  input  logic [SW-1:0] idx,
  output logic [N-1:0]  ref_code
);

  localparam logic [N-1:0] MID = N'(1) << (N - 1);

  logic [N-1:0] w_next;

  always_comb begin
    w_next = N'(step_weight(int'(idx) + 1, N));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_code <= '0;
    end else if (init) begin
      ref_code <= MID;
    end else if (adv) begin
      ref_code <= up ? (ref_code + w_next) : (ref_code - w_next);
    end
  end

  // The weight chain keeps the reference inside 1 .. 2^N-1.
  AST_REF_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    adv |=> (ref_code != '0)); // R3

endmodule

// File: rtl/psr_pair_encoder.sv
module psr_pair_encoder #(
  parameter int N = 8
) (
  input  logic [2*(N-1)-1:0] dec,
  output logic [N-1:0]       code
);

  localparam int M = 2 * (N - 1);
  localparam int H = N - 2;

  logic [H-1:0] xw;
  logic [H-1:0] yw;
  logic [H-1:0] sum;
  logic [H:0]   cy;

  genvar i;
  generate
    for (i = 0; i < H; i++) begin : g_pack
      assign xw[H-1-i] = dec[2*i];
      assign yw[H-1-i] = dec[2*i+1];
    end
  endgenerate

  assign cy[0] = dec[M-2];

  generate
    for (i = 0; i < H; i++) begin : g_fa
      assign sum[i]  = xw[i] ^ yw[i] ^ cy[i];
      assign cy[i+1] = (xw[i] & yw[i]) | (xw[i] & cy[i]) | (yw[i] & cy[i]);
    end
  endgenerate

  assign code = {cy[H], sum, dec[M-1]};

endmodule

// File: rtl/psr_sar_seq.sv
module psr_sar_seq
  import psr_pkg::*;
#(
  parameter int N  = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          cmp_bit,
  input  logic [CW-1:0] short_cyc,
  input  logic [CW-1:0] long_cyc,
  output logic [N-1:0]  dac_code,
  output logic          cmp_strobe,
  output logic [N-1:0]  result,
  output logic          done
);

  localparam int M  = 2 * (N - 1);
  localparam int SW = $clog2(M);
  localparam logic [N-1:0] MID = N'(1) << (N - 1);

  logic          busy;
  logic [SW-1:0] idx;
  logic [M-2:0]  dec;
  logic          launch;
  logic          last_step;
  logic          step_adv;
  logic          finish;
  logic          tm_load;
  per_kind_e     tm_kind;
  logic [N-1:0]  enc_code;

  assign launch    = start && !busy;
  assign last_step = (idx == SW'(M - 1));
  assign step_adv  = busy && cmp_strobe && !last_step;
  assign finish    = busy && cmp_strobe && last_step;
  assign tm_load   = launch || step_adv;
  assign tm_kind   = launch ? step_kind(0, M) : step_kind(int'(idx) + 1, M);

  psr_step_timer #(.CW(CW)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load      (tm_load),
    .kind      (tm_kind),
    .short_cyc (short_cyc),
    .long_cyc  (long_cyc),
    .strobe    (cmp_strobe)
  );

  psr_ref_track #(.N(N), .SW(SW)) u_ref (
    .clk      (clk),
    .rst      (rst),
    .init     (launch),
    .adv      (step_adv),
    .up       (cmp_bit),
    .idx      (idx),
    .ref_code (dac_code)
  );

  // The last decision is fed straight in, so the code is ready at the final strobe edge.
  psr_pair_encoder #(.N(N)) u_enc (
    .dec  ({cmp_bit, dec}),
    .code (enc_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      idx    <= '0;
      dec    <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        busy <= 1'b1;
        idx  <= '0;
        dec  <= '0;
      end else if (step_adv) begin
        dec[idx] <= cmp_bit;
        idx      <= idx + SW'(1);
      end else if (finish) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        result <= enc_code;
      end
    end
  end

  AST_FIRST_REF: assert property (@(posedge clk) disable iff (rst)
    launch |=> (dac_code == MID)); // R2

  AST_REF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (busy && !cmp_strobe) |=> $stable(dac_code)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_CODE_MATCH: assert property (@(posedge clk) disable iff (rst)
    done |-> (result == ($past(cmp_bit) ? dac_code : dac_code - N'(1)))); // R10

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result)); // R8

endmodule

// File: tb/sim_psr_sar_seq.sv
`timescale 1ns/1ps
module sim_psr_sar_seq;

  localparam int NB = 6;
  localparam int CB = 4;
  localparam int MM = 2 * (NB - 1);
  localparam int NV = 12;

  // level, error step (0 = none), short, long, expected code
  localparam int VEC [NV][5] = '{
    '{0,  0, 2, 3, 0},
    '{63, 0, 2, 3, 63},
    '{32, 1, 2, 3, 32},
    '{31, 1, 2, 3, 31},
    '{17, 2, 1, 1, 17},
    '{45, 3, 0, 2, 45},
    '{20, 4, 3, 5, 20},
    '{50, 7, 1, 4, 50},
    '{8,  8, 2, 3, 8},
    '{41, 5, 4, 1, 41},
    '{1,  0, 0, 0, 1},
    '{62, 6, 5, 7, 62}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          cmp_bit = 1'b0;
  logic [CB-1:0] short_cyc = '0;
  logic [CB-1:0] long_cyc = '0;
  logic [NB-1:0] dac_code;
  logic          cmp_strobe;
  logic [NB-1:0] result;
  logic          done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int wt [0:MM+1];
  int qm [0:MM+1];

  always #5 clk = ~clk;

  psr_sar_seq #(.N(NB), .CW(CB)) u0 (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cmp_bit    (cmp_bit),
    .short_cyc  (short_cyc),
    .long_cyc   (long_cyc),
    .dac_code   (dac_code),
    .cmp_strobe (cmp_strobe),
    .result     (result),
    .done       (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bper(input int k, input int ts, input int tl);
    int s;
    int l;
    s = (ts == 0) ? 1 : ts;
    l = (tl == 0) ? 1 : tl;
    if (k == 1) return s;
    if (k == MM - 1) return 2 * s;
    if (k == MM) return l;
    return (k % 2 == 1) ? s : l;
  endfunction

  // Weights built backwards from the margin recurrence, independent of the RTL formula.
  task automatic build_model();
    for (int k = 0; k <= MM + 1; k++) begin
      wt[k] = 0;
      qm[k] = 0;
    end
    wt[MM] = 1;
    wt[MM-1] = 1;
    for (int k = MM - 2; k >= 1; k--) begin
      int acc;
      acc = 1 - wt[k+1];
      for (int i = k + 2; i <= MM; i++) acc += wt[i];
      qm[k] = acc;
      if (k >= 2) wt[k] = acc;
    end
    wt[1] = 1 << (NB - 1);
  endtask

  task automatic run_conv(input int lvl, input int errk, input int ts, input int tl,
                          input int exp, input bit force_err, input bit hit_last,
                          input bit chain, input bit pre_started);
    int vr;
    int step;
    int gap;
    int guard;
    int pred;
    int use_exp;
    string tag;
    bit d;
    short_cyc = CB'(ts);
    long_cyc  = CB'(tl);
    if (!pre_started) start = 1'b1;
    vr = wt[1];
    step = 0;
    gap = 0;
    guard = 0;
    pred = 0;
    while (step < MM && guard < 2000) begin
      @(negedge clk);
      guard++;
      gap++;
      start = 1'b0;
      if (cmp_strobe) begin
        step++;
        chk(int'(dac_code) == vr, (step == 1) ? "R2" : "R3", int'(dac_code), vr);
        if (step == 1) tag = "R4";
        else if (step >= MM - 1) tag = "R6";
        else tag = "R5";
        chk(gap == bper(step, ts, tl), tag, gap, bper(step, ts, tl));
        d = (lvl >= vr);
        if (step == errk) begin
          int diff;
          diff = 2 * lvl + 1 - 2 * vr;
          if (diff < 0) diff = -diff;
          if (force_err || diff < 2 * qm[step]) d = ~d;
        end
        cmp_bit = d;
        if (step < MM) vr = d ? vr + wt[step+1] : vr - wt[step+1];
        else pred = d ? vr : vr - 1;
        if (hit_last && step == MM) start = 1'b1;
        gap = 0;
      end else begin
        cmp_bit = ~(lvl >= int'(dac_code));
      end
    end
    chk(guard < 2000, "R8", guard, 2000);
    use_exp = (exp < 0) ? pred : exp;
    @(negedge clk);
    start = chain;
    chk(done == 1'b1, "R8", int'(done), 1);
    chk(int'(result) == use_exp, (exp < 0) ? "R10" : ((errk != 0) ? "R9" : "R8"),
        int'(result), use_exp);
    if (!chain) begin
      @(negedge clk);
      chk(done == 1'b0, "R8", int'(done), 0);
      chk(int'(result) == use_exp, "R8", int'(result), use_exp);
      if (hit_last) begin
        int seen;
        seen = 0;
        for (int c = 0; c < 2 * (tl + ts) + 6; c++) begin
          @(negedge clk);
          if (cmp_strobe || done) seen++;
        end
        chk(seen == 0, "R11", seen, 0);
      end
    end
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    build_model();
    repeat (3) @(negedge clk);
    // R1: state during and right after reset
    chk(dac_code == '0 && cmp_strobe == 1'b0, "R1", int'(dac_code), 0);
    chk(result == '0 && done == 1'b0, "R1", int'(result), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(dac_code == '0 && cmp_strobe == 1'b0, "R1", int'(dac_code), 0);
    chk(result == '0 && done == 1'b0, "R1", int'(result), 0);

    // Vector table: R4 R5 R6 R9 R12 across several period settings
    for (int v = 0; v < NV; v++) begin
      run_conv(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 1'b0, 1'b0, 1'b0, 1'b0);
    end

    // R8: every level with a clean comparator (R7 garbage between strobes)
    for (int lv = 0; lv < (1 << NB); lv++) begin
      run_conv(lv, 0, 2, 3, lv, 1'b0, 1'b0, 1'b0, 1'b0);
    end

    // R9: single decision error at each correctable step, inside the margin
    for (int lv = 0; lv < (1 << NB); lv++) begin
      for (int ek = 1; ek <= MM - 2; ek++) begin
        run_conv(lv, ek, 1, 2, lv, 1'b0, 1'b0, 1'b0, 1'b0);
      end
    end

    // R10: forced wrong last decision, code follows the final-reference rule
    run_conv(37, MM, 2, 3, -1, 1'b1, 1'b0, 1'b0, 1'b0);
    run_conv(12, MM, 2, 3, -1, 1'b1, 1'b0, 1'b0, 1'b0);

    // R12: zero counts become one cycle
    run_conv(27, 0, 0, 0, 27, 1'b0, 1'b0, 1'b0, 1'b0);

    // R11: start in the final strobe cycle is dropped
    run_conv(44, 0, 2, 3, 44, 1'b0, 1'b1, 1'b0, 1'b0);
    // R11: start in the done cycle launches the next conversion at once
    run_conv(9, 0, 3, 2, 9, 1'b0, 1'b0, 1'b1, 1'b0);
    run_conv(58, 0, 3, 2, 58, 1'b0, 1'b0, 1'b0, 1'b1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule